// File: doc/BRIEF.md
# Joint-Bit Modular Exponentiation Sequencer

This block drives an external modular multiplier so that it computes g0^e0 · g1^e1 mod m by scanning both exponents together, one bit pair per step. The multiplier holds four operand slots. Slot 0 holds g0, slot 1 holds g1 and slot 2 holds their product; all three are filled in advance by other logic. Slot 3 is the accumulator and must hold the Montgomery-domain one before a run. The sequencer only chooses which slots feed the multiplier and where the result goes. It talks to the multiplier through a start pulse and a done pulse.

The exponents arrive through a small push queue with a valid/ready interface. Each 32-bit word carries one 16-bit slice of e1 in its upper half and the slice of e0 with the same weight in its lower half. Slices are pushed most significant first. A push is accepted on a cycle where both `exp_in_valid` and `exp_in_ready` are high. When the queue is full, `exp_in_ready` is low and `exp_full` is high. A push offered in that state is dropped, and `exp_nopush` pulses to report it.

With `run_auto` high, a one-cycle `start` launches a full exponentiation. For every bit pair the accumulator is squared, then multiplied by slot 0, 1 or 2 when the pair is not zero. A one-cycle `ready` pulse marks the end. With `run_auto` low, `start` issues exactly one multiplication that uses the select inputs as given.

Top module: `shamir_exp_seq`

## Requirements
- R1: A queue word carries the e1 slice in bits 31:16 and the e0 slice in bits 15:0. The first word pushed carries the most significant slices of both exponents.
- R2: Inside a word, bit 15 of each half is used first and bit 0 last. The next word is popped only after all 16 bit pairs of the current word have been used.
- R3: Each bit pair begins with a square: `mul_x`=3, `mul_y`=3, `mul_dst`=3.
- R4: After the square, a pair (e1,e0)=00 issues nothing more. Pair 01 issues x=3, y=0, dst=3. Pair 10 issues x=3, y=1, dst=3. Pair 11 issues x=3, y=2, dst=3. An automatic run therefore issues 16 operations per word plus one for each nonzero pair.
- R5: In automatic mode, `ready` pulses for exactly one cycle after the last operation's `mul_done`. The accumulator then holds g0^e0·g1^e1.
- R6: An automatic start with an empty queue pulses `ready` and issues no `mul_start`.
- R7: With `run_auto` low, `start` issues exactly one operation using `sel_x_in`, `sel_y_in` and `sel_dst_in` as they were at the start cycle. `ready` pulses once after its `mul_done`.
- R8: The queue holds FIFO_DEPTH words. `exp_in_ready` is low and `exp_full` is high exactly when the queue is full.
- R9: A push offered while the queue is full is dropped and leaves the queue contents unchanged. `exp_nopush` is high for one cycle on the following cycle.
- R10: A `start` that arrives while a run is in progress has no effect on the operations issued.
- R11: `mul_start` is a one-cycle pulse. The selects stay stable while an operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_in_valid | input | 1 | Exponent word offered |
| exp_in_ready | output | 1 | Queue can accept a word |
| exp_in_data | input | 2*SLICE | {e1 slice, e0 slice} |
| exp_full | output | 1 | Queue full |
| exp_nopush | output | 1 | Previous-cycle push was dropped |
| start | input | 1 | One-cycle launch pulse |
| run_auto | input | 1 | 1: full exponentiation, 0: single operation |
| sel_x_in | input | 2 | x slot for single operation |
| sel_y_in | input | 2 | y slot for single operation |
| sel_dst_in | input | 2 | Destination slot for single operation |
| ready | output | 1 | One-cycle completion pulse |
| mul_start | output | 1 | Launch multiplier operation |
| mul_x | output | 2 | Multiplier x slot |
| mul_y | output | 2 | Multiplier y slot |
| mul_dst | output | 2 | Multiplier destination slot |
| mul_done | input | 1 | Multiplier finished (one-cycle pulse) |

## Verification
The bench builds the block with FIFO_DEPTH=2 and keeps the default SLICE=16. With two entries, the queue fills after two pushes, so a third push makes the full flag, the dropped push and the unchanged contents visible within a few cycles. Two words are also the longest exponents the bench uses, so 32-bit exponents exercise the pop of a second word and confirm that the first word pushed is taken as the most significant. The multiplier model in the bench does real arithmetic modulo a small prime, so any misordered bit or wrong slot shows up in the final accumulator value.

// File: rtl/shamir_pkg.sv
package shamir_pkg;
  localparam logic [1:0] SLOT_G0  = 2'd0;
  localparam logic [1:0] SLOT_G1  = 2'd1;
  localparam logic [1:0] SLOT_G01 = 2'd2;
  localparam logic [1:0] SLOT_ACC = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SQ_GO, ST_SQ_WAIT, ST_MU_GO, ST_MU_WAIT, ST_SG_GO, ST_SG_WAIT
  } seq_state_t;

  // nonzero bit pair {e1,e0} -> multiplicand slot
  function automatic logic [1:0] pair_slot(input logic [1:0] pair);
    return pair - 2'd1;
  endfunction
endpackage

// File: rtl/exp_fifo.sv
module exp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         full,
  output logic         nopush,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign in_ready = !full;
  assign do_wr    = in_valid && in_ready;
  assign do_rd    = pop && !empty;
  assign out_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; nopush <= 1'b0;
    end else begin
      nopush <= in_valid && !in_ready;
      if (do_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r9_nopush_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> nopush);
  a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !pop) |=> $stable(cnt));
endmodule

// File: rtl/pair_shifter.sv
module pair_shifter #(
  parameter int SLICE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*SLICE-1:0] word,
  input  logic               shift,
  output logic [1:0]         pair,
  output logic               has_bits
);
  localparam int LW = $clog2(SLICE + 1);

  logic [SLICE-1:0] hi, lo;
  logic [LW-1:0]    left;

  assign pair     = {hi[SLICE-1], lo[SLICE-1]};
  assign has_bits = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0; lo <= '0; left <= '0;
    end else if (load) begin
      hi   <= word[2*SLICE-1:SLICE];
      lo   <= word[SLICE-1:0];
      left <= LW'(SLICE);
    end else if (shift) begin
      hi   <= hi << 1;
      lo   <= lo << 1;
      left <= left - 1'b1;
    end
  end

  a_r2_shift_needs_bits: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> has_bits);
  a_r2_load_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !has_bits);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import shamir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run_auto,
  input  logic [1:0] sel_x_in,
  input  logic [1:0] sel_y_in,
  input  logic [1:0] sel_dst_in,
  input  logic       fifo_empty,
  input  logic       has_bits,
  input  logic [1:0] pair,
  input  logic       mul_done,
  output logic       pop,
  output logic       shift,
  output logic       mul_start,
  output logic [1:0] mul_x,
  output logic [1:0] mul_y,
  output logic [1:0] mul_dst,
  output logic       done
);
  seq_state_t st;
  logic       waiting;

  assign pop       = (st == ST_FETCH) && !has_bits && !fifo_empty;
  assign shift     = (st == ST_SQ_WAIT) && mul_done;
  assign mul_start = (st == ST_SQ_GO) || (st == ST_MU_GO) || (st == ST_SG_GO);
  assign waiting   = (st == ST_SQ_WAIT) || (st == ST_MU_WAIT) || (st == ST_SG_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; done <= 1'b0;
      mul_x <= SLOT_ACC; mul_y <= SLOT_ACC; mul_dst <= SLOT_ACC;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (run_auto) st <= ST_FETCH;
          else begin
            mul_x <= sel_x_in; mul_y <= sel_y_in; mul_dst <= sel_dst_in;
            st <= ST_SG_GO;
          end
        end
        ST_FETCH: if (has_bits) begin
          mul_x <= SLOT_ACC; mul_y <= SLOT_ACC; mul_dst <= SLOT_ACC;
          st <= ST_SQ_GO;
        end else if (fifo_empty) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        ST_SQ_GO:   st <= ST_SQ_WAIT;
        ST_SQ_WAIT: if (mul_done) begin
          if (pair != 2'b00) begin
            mul_y <= pair_slot(pair);
            st    <= ST_MU_GO;
          end else st <= ST_FETCH;
        end
        ST_MU_GO:   st <= ST_MU_WAIT;
        ST_MU_WAIT: if (mul_done) st <= ST_FETCH;
        ST_SG_GO:   st <= ST_SG_WAIT;
        ST_SG_WAIT: if (mul_done) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |=> !mul_start);
  a_r11_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !mul_done) |=> $stable({mul_x, mul_y, mul_dst}));
  a_r3_square_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SQ_GO) |-> (mul_x == SLOT_ACC && mul_y == SLOT_ACC && mul_dst == SLOT_ACC));
  a_r4_mult_to_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MU_GO) |-> (mul_x == SLOT_ACC && mul_dst == SLOT_ACC && mul_y != SLOT_ACC));
  a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/shamir_exp_seq.sv
module shamir_exp_seq #(
  parameter int FIFO_DEPTH = 4,
  parameter int SLICE      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exp_in_valid,
  output logic               exp_in_ready,
  input  logic [2*SLICE-1:0] exp_in_data,
  output logic               exp_full,
  output logic               exp_nopush,
  input  logic               start,
  input  logic               run_auto,
  input  logic [1:0]         sel_x_in,
  input  logic [1:0]         sel_y_in,
  input  logic [1:0]         sel_dst_in,
  output logic               ready,
  output logic               mul_start,
  output logic [1:0]         mul_x,
  output logic [1:0]         mul_y,
  output logic [1:0]         mul_dst,
  input  logic               mul_done
);
  localparam int WORD_W = 2 * SLICE;

  logic              pop, shift, empty, has_bits;
  logic [WORD_W-1:0] head;
  logic [1:0]        pair;

  exp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(exp_in_valid), .in_ready(exp_in_ready),
    .in_data(exp_in_data), .full(exp_full), .nopush(exp_nopush),
    .pop(pop), .empty(empty), .out_data(head));

  pair_shifter #(.SLICE(SLICE)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(pop), .word(head), .shift(shift),
    .pair(pair), .has_bits(has_bits));

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .run_auto(run_auto),
    .sel_x_in(sel_x_in), .sel_y_in(sel_y_in), .sel_dst_in(sel_dst_in),
    .fifo_empty(empty), .has_bits(has_bits), .pair(pair), .mul_done(mul_done),
    .pop(pop), .shift(shift), .mul_start(mul_start), .mul_x(mul_x),
    .mul_y(mul_y), .mul_dst(mul_dst), .done(ready));
endmodule

// File: tb/tb_shamir_exp_seq.sv
module tb_shamir_exp_seq;
  localparam int    DEPTH = 2;
  localparam int    LAT   = 3;
  localparam longint MODP = 65521;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exp_in_valid = 1'b0, exp_in_ready, exp_full, exp_nopush;
  logic [31:0] exp_in_data = '0;
  logic start = 1'b0, run_auto = 1'b0, ready, mul_start, mul_done;
  logic [1:0] sel_x_in = '0, sel_y_in = '0, sel_dst_in = '0, mul_x, mul_y, mul_dst;

  always #2.5 clk = ~clk;

  shamir_exp_seq #(.FIFO_DEPTH(DEPTH), .SLICE(16)) dut (
    .clk(clk), .rst_n(rst_n), .exp_in_valid(exp_in_valid), .exp_in_ready(exp_in_ready),
    .exp_in_data(exp_in_data), .exp_full(exp_full), .exp_nopush(exp_nopush),
    .start(start), .run_auto(run_auto), .sel_x_in(sel_x_in), .sel_y_in(sel_y_in),
    .sel_dst_in(sel_dst_in), .ready(ready), .mul_start(mul_start), .mul_x(mul_x),
    .mul_y(mul_y), .mul_dst(mul_dst), .mul_done(mul_done));

  // multiplier model: four slots, real arithmetic mod MODP
  longint opr [4];
  longint pre [4];
  logic preload = 1'b0, auto_chk = 1'b0;
  int op_cnt = 0, shape_err = 0, rdy_cnt = 0, lat_cnt = 0;
  logic [1:0] cx, cy, cd;
  logic mdone = 1'b0;
  assign mul_done = mdone;

  always @(posedge clk) begin
    mdone <= 1'b0;
    if (ready) rdy_cnt <= rdy_cnt + 1;
    if (preload) begin
      for (int i = 0; i < 4; i++) opr[i] <= pre[i];
      op_cnt <= 0; shape_err <= 0; rdy_cnt <= 0; lat_cnt <= 0;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mdone   <= 1'b1;
        opr[cd] <= (opr[cx] * opr[cy]) % MODP;
      end
    end else if (mul_start) begin
      cx <= mul_x; cy <= mul_y; cd <= mul_dst;
      lat_cnt <= LAT;
      op_cnt  <= op_cnt + 1;
      if (auto_chk && (mul_x != 2'd3 || mul_dst != 2'd3)) shape_err <= shape_err + 1;
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic longint powmod(input longint b, input logic [31:0] e, input int nb);
    longint r = 1;
    for (int i = nb - 1; i >= 0; i--) begin
      r = (r * r) % MODP;
      if (e[i]) r = (r * b) % MODP;
    end
    return r;
  endfunction

  task automatic load_model(input longint g0, input longint g1);
    pre[0] = g0; pre[1] = g1; pre[2] = (g0 * g1) % MODP; pre[3] = 1;
    preload = 1'b1; tick(1); preload = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    exp_in_valid = 1'b1; exp_in_data = w; tick(1); exp_in_valid = 1'b0;
  endtask

  task automatic pulse_start(input logic auto);
    run_auto = auto; start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic wait_ready(input bit restart);
    for (int i = 0; i < 20000 && rdy_cnt == 0; i++) begin
      if (restart && i == 30) pulse_start(1'b1);   // R10: ignored while busy
      else tick(1);
    end
    tick(3);
  endtask

  // vector: {nwords[1:0], e1[31:0], e0[31:0], g0[15:0], g1[15:0]}
  localparam logic [97:0] VEC [5] = '{
    {2'd1, 32'h0000_0000, 32'h0000_0001, 16'd3,    16'd5},
    {2'd1, 32'h0000_FFFF, 32'h0000_FFFF, 16'd7,    16'd11},
    {2'd1, 32'h0000_A5A5, 32'h0000_5A5A, 16'd2,    16'd9},
    {2'd2, 32'h1234_5678, 32'h9ABC_DEF0, 16'd1234, 16'd4321},
    {2'd2, 32'h8000_0000, 32'h0000_0001, 16'd17,   16'd19}
  };

  initial begin
    tick(3);
    check("R8 reset ready_in", exp_in_ready, 1);
    check("R8 reset full", exp_full, 0);
    check("R9 reset nopush", exp_nopush, 0);
    check("R5 reset ready", ready, 0);
    check("R11 reset mul_start", mul_start, 0);
    rst_n = 1'b1; tick(2);

    // R6: automatic start on empty queue
    load_model(3, 5); auto_chk = 1'b1;
    pulse_start(1'b1); tick(6);
    check("R6 empty ready pulses", rdy_cnt, 1);
    check("R6 empty no ops", op_cnt, 0);

    // R1 R2 R3 R4 R5 R10: vector walk
    for (int v = 0; v < 5; v++) begin
      logic [1:0]  nw = VEC[v][97:96];
      logic [31:0] e1 = VEC[v][95:64];
      logic [31:0] e0 = VEC[v][63:32];
      longint g0 = longint'(VEC[v][31:16]);
      longint g1 = longint'(VEC[v][15:0]);
      int nb = 16 * int'(nw);
      logic [31:0] msk = (nw == 2'd2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      longint expv = (powmod(g0, e0, nb) * powmod(g1, e1, nb)) % MODP;
      load_model(g0, g1);
      if (nw == 2'd2) push({e1[31:16], e0[31:16]});   // R1: most significant first
      push({e1[15:0], e0[15:0]});
      pulse_start(1'b1);
      wait_ready(v == 3);
      check("R5 R1 R2 accumulator", opr[3], expv);
      check("R3 R4 op count", op_cnt, nb + $countones((e0 | e1) & msk));
      check("R3 R4 slot shape", shape_err, 0);
      check("R5 R10 single ready", rdy_cnt, 1);
    end

    // R7: single operation with external selects
    auto_chk = 1'b0;
    load_model(10, 20);
    sel_x_in = 2'd0; sel_y_in = 2'd1; sel_dst_in = 2'd2;
    pulse_start(1'b0);
    wait_ready(1'b0);
    check("R7 single op count", op_cnt, 1);
    check("R7 single dest", opr[2], 200);
    check("R7 acc untouched", opr[3], 1);
    check("R7 ready", rdy_cnt, 1);

    // R8 R9: fill queue, drop a push, contents unchanged
    auto_chk = 1'b1;
    load_model(5, 6);
    push(32'h0003_0002);
    push(32'h0001_0005);
    check("R8 full flag", exp_full, 1);
    check("R8 in_ready low", exp_in_ready, 0);
    exp_in_valid = 1'b1; exp_in_data = 32'hFFFF_FFFF; tick(1);
    check("R9 nopush pulse", exp_nopush, 1);
    exp_in_valid = 1'b0; tick(1);
    check("R9 nopush clears", exp_nopush, 0);
    pulse_start(1'b1);
    wait_ready(1'b0);
    check("R9 contents kept", opr[3],
          (powmod(5, 32'h0002_0005, 32) * powmod(6, 32'h0003_0001, 32)) % MODP);
    check("R9 op count", op_cnt, 32 + $countones(32'h0003_0005));
    check("R8 queue drained", exp_in_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule